// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit sits between a processor's memory stage and a 32-bit data memory whose read port returns the addressed word in the same cycle. It forms the effective address from a base register and a signed 16-bit displacement. For stores it produces per-byte write enables and a store word with the data copied into every lane it could occupy. For loads it takes the addressed byte or halfword from the returned word, extends it to 32 bits and registers the result.

A static `bigEndian` input selects the lane order, so the same unit serves either byte ordering. Halfword and word accesses that are not naturally aligned are flagged and suppressed. Byte accesses are accepted at any address.

Top module: `lsu_lane_unit`

## Requirements
- R1: `memAddr` equals `baseAddr` plus `offset` sign-extended to 32 bits, in the same cycle, with wrap-around modulo 2^32.
- R2: With `reqValid` high, `alignFault` is high in the same cycle for a halfword access (`reqSize`=1) whose address bit 0 is set, and for a word access (`reqSize`=2, or the reserved code 3, which is treated as a word) whose address bits 1:0 are not both zero.
- R3: A byte access (`reqSize`=0) never raises `alignFault`, whatever its address.
- R4: For an aligned store, `memWe` (bit i enables data bits 8i+7:8i) is: byte at offset o → bit o in little-endian mode, bit 3−o in big-endian mode; halfword at offset 0 → 4'b0011 little-endian or 4'b1100 big-endian, and at offset 2 the reverse; word → 4'b1111.
- R5: `memWdata` holds the low byte of `storeData` in all four lanes for a byte access, the low halfword in both halves for a halfword access, and `storeData` unchanged for a word access.
- R6: A load picks byte offset o from data bits 8o+7:8o in little-endian mode and from bits 31−8o:24−8o in big-endian mode. It picks the halfword at offset 0 from bits 15:0 in little-endian mode and from bits 31:16 in big-endian mode, with offset 2 taking the other half.
- R7: With `reqSigned`=1, a loaded byte or halfword is sign-extended to 32 bits; with `reqSigned`=0 it is zero-extended (byte 0xF0 loads as 0xFFFFFFF0 or 0x000000F0). A word load is passed through unchanged.
- R8: An aligned load updates `loadData` at the clock edge that ends the request cycle, and `loadDone` is high for exactly the following cycle.
- R9: On an alignment fault, `memWe` is 4'b0000, `loadData` keeps its value and `loadDone` stays low in the next cycle.
- R10: After reset, `loadData` is 0 and `loadDone` is 0.
- R11: Storing bytes 0x11, 0x22, 0x33, 0x44 at byte offsets 0 to 3 of a word and then loading that word gives 0x11223344 in big-endian mode and 0x44332211 in little-endian mode.
- R12: With `reqValid` low, `memWe` is 4'b0000 and `loadDone` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | 1 selects big-endian lane order, 0 little-endian |
| reqValid | input | 1 | Access request in this cycle |
| reqStore | input | 1 | 1 store, 0 load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| reqSigned | input | 1 | Sign-extend a loaded byte or halfword |
| baseAddr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| storeData | input | 32 | Register value to store |
| memRdata | input | 32 | Word read at memAddr in the same cycle |
| memAddr | output | 32 | Effective byte address |
| memWe | output | 4 | Per-byte write enables |
| memWdata | output | 32 | Lane-replicated store data |
| alignFault | output | 1 | Misaligned halfword or word access |
| loadData | output | 32 | Registered, extended load result |
| loadDone | output | 1 | loadData was updated at the last edge |

## Verification
The embedded assertions check on every cycle that byte accesses never fault, that a faulting access writes no lane, that aligned byte and halfword stores enable exactly one or two lanes, and that a faulting request leaves the load register untouched. Only the bench can show that the right lane is chosen for each offset and byte order, that the extension matches the loaded value, and that stored bytes come back in the order each mode requires. It does this against a small memory model with both orderings.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0]  laneWe;
    logic [LANE_W-1:0] byteLane;
    logic              selHighHalf;
    logic              fault;
    logic              loadCapture;
    accSize_e          size;
    logic              signExt;
  } lsuStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [LANE_W-1:0] addrLow,
  output lsuStrobe_t        strb
);
  accSize_e sizeE;
  logic     misaligned;
  logic [LANE_W-1:0] lane;
  logic     highHalf;
  logic [LANES-1:0] rawWe;

  assign sizeE = accSize_e'(reqSize);

  always_comb begin
    case (sizeE)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addrLow[0];
      default: misaligned = (addrLow != '0);
    endcase
  end

  assign lane     = bigEndian ? ~addrLow : addrLow;
  assign highHalf = bigEndian ? ~addrLow[1] : addrLow[1];

  always_comb begin
    case (sizeE)
      SZ_BYTE: rawWe = LANES'(1) << lane;
      SZ_HALF: rawWe = highHalf ? 4'b1100 : 4'b0011;
      default: rawWe = '1;
    endcase
  end

  always_comb begin
    strb.laneWe      = (reqValid && reqStore && !misaligned) ? rawWe : '0;
    strb.byteLane    = lane;
    strb.selHighHalf = highHalf;
    strb.fault       = reqValid && misaligned;
    strb.loadCapture = reqValid && !reqStore && !misaligned;
    strb.size        = sizeE;
    strb.signExt     = reqSigned;
  end

  AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sizeE == SZ_BYTE) |-> !strb.fault); // R3
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fault |-> (strb.laneWe == '0)); // R9
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && sizeE == SZ_BYTE) |-> ($countones(strb.laneWe) == 1)); // R4
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && sizeE == SZ_HALF && !strb.fault) |-> ($countones(strb.laneWe) == 2)); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (strb.laneWe == '0)); // R12
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        strb,
  input  logic [DATA_W-1:0] baseAddr,
  input  logic [OFFS_W-1:0] offset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic              loadDone
);
  localparam int BYTE_W = DATA_W / LANES;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int HALVES = LANES / 2;

  logic [DATA_W-1:0] byteRep, halfRep, extended;
  logic [BYTE_W-1:0] pickedByte;
  logic [HALF_W-1:0] pickedHalf;

  assign effAddr = baseAddr + {{(DATA_W-OFFS_W){offset[OFFS_W-1]}}, offset};

  for (genvar l = 0; l < LANES; l++) begin : gByteRep
    assign byteRep[l*BYTE_W +: BYTE_W] = storeData[BYTE_W-1:0];
  end
  for (genvar h = 0; h < HALVES; h++) begin : gHalfRep
    assign halfRep[h*HALF_W +: HALF_W] = storeData[HALF_W-1:0];
  end

  always_comb begin
    case (strb.size)
      SZ_BYTE: memWdata = byteRep;
      SZ_HALF: memWdata = halfRep;
      default: memWdata = storeData;
    endcase
  end

  assign pickedByte = memRdata[strb.byteLane*BYTE_W +: BYTE_W];
  assign pickedHalf = strb.selHighHalf ? memRdata[DATA_W-1 -: HALF_W] : memRdata[HALF_W-1:0];

  always_comb begin
    case (strb.size)
      SZ_BYTE: extended = {{(DATA_W-BYTE_W){strb.signExt & pickedByte[BYTE_W-1]}}, pickedByte};
      SZ_HALF: extended = {{(DATA_W-HALF_W){strb.signExt & pickedHalf[HALF_W-1]}}, pickedHalf};
      default: extended = memRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadData <= '0;
      loadDone <= 1'b0;
    end else begin
      loadDone <= strb.loadCapture;
      if (strb.loadCapture) loadData <= extended;
    end
  end

  AST_FAULT_HOLDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.fault |=> ($stable(loadData) && !loadDone)); // R9
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCapture && !strb.signExt && strb.size == SZ_BYTE)
      |=> (loadDone && loadData[DATA_W-1:BYTE_W] == '0)); // R7
  AST_DONE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCapture |=> loadDone); // R8
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [DATA_W-1:0] baseAddr,
  input  logic [OFFS_W-1:0] offset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              alignFault,
  output logic [DATA_W-1:0] loadData,
  output logic              loadDone
);
  lsuStrobe_t strb;

  lsu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .reqValid(reqValid),
    .reqStore(reqStore), .reqSize(reqSize), .reqSigned(reqSigned),
    .addrLow(memAddr[LANE_W-1:0]), .strb(strb)
  );

  lsu_datapath #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .baseAddr(baseAddr), .offset(offset),
    .storeData(storeData), .memRdata(memRdata), .effAddr(memAddr),
    .memWdata(memWdata), .loadData(loadData), .loadDone(loadDone)
  );

  assign memWe      = strb.laneWe;
  assign alignFault = strb.fault;
endmodule

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        bigEndian = 0, reqValid = 0, reqStore = 0, reqSigned = 0;
  logic [1:0]  reqSize = 0;
  logic [31:0] baseAddr = 0, storeData = 0, memRdata;
  logic [15:0] offset = 0;
  logic [31:0] memAddr, memWdata, loadData;
  logic [3:0]  memWe;
  logic        alignFault, loadDone;

  int testCount = 0;
  int failCount = 0;

  logic [31:0] mem [4];
  logic [31:0] sAddr, sWdata;
  logic [3:0]  sWe;
  logic        sFault;

  always #5 clk = ~clk;

  lsu_lane_unit dut (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .reqValid(reqValid),
    .reqStore(reqStore), .reqSize(reqSize), .reqSigned(reqSigned),
    .baseAddr(baseAddr), .offset(offset), .storeData(storeData),
    .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .alignFault(alignFault), .loadData(loadData), .loadDone(loadDone)
  );

  assign memRdata = mem[memAddr[3:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < 4; l++)
        if (memWe[l]) mem[memAddr[3:2]][l*8 +: 8] <= memWdata[l*8 +: 8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request cycle; comb outputs captured before the edge
  task automatic access(input logic be, input logic st, input logic [1:0] sz, input logic sg,
                        input logic [31:0] b, input logic [15:0] off, input logic [31:0] sd);
    @(negedge clk);
    bigEndian = be; reqValid = 1; reqStore = st; reqSize = sz; reqSigned = sg;
    baseAddr = b; offset = off; storeData = sd;
    #1;
    sAddr = memAddr; sWe = memWe; sWdata = memWdata; sFault = alignFault;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0;
    #1;
    sWe = memWe;
    @(posedge clk); #1;
  endtask

  // {bigEndian, size, signed, byteOffset, expected}; word 0xF0817263 at 0x100
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b1, 2'd0, 32'h00000063},
    {1'b0, 2'd0, 1'b1, 2'd3, 32'hFFFFFFF0},
    {1'b0, 2'd0, 1'b0, 2'd3, 32'h000000F0},
    {1'b0, 2'd0, 1'b0, 2'd2, 32'h00000081},
    {1'b1, 2'd0, 1'b0, 2'd0, 32'h000000F0},
    {1'b1, 2'd0, 1'b1, 2'd0, 32'hFFFFFFF0},
    {1'b1, 2'd0, 1'b1, 2'd1, 32'hFFFFFF81},
    {1'b1, 2'd0, 1'b1, 2'd3, 32'h00000063},
    {1'b0, 2'd1, 1'b1, 2'd0, 32'h00007263},
    {1'b0, 2'd1, 1'b1, 2'd2, 32'hFFFFF081},
    {1'b0, 2'd1, 1'b0, 2'd2, 32'h0000F081},
    {1'b1, 2'd1, 1'b1, 2'd0, 32'hFFFFF081},
    {1'b1, 2'd1, 1'b0, 2'd2, 32'h00007263}
  };

  initial begin
    #100000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 loadData reset", loadData, 32'h0);
    check("R10 loadDone reset", {31'b0, loadDone}, 32'h0);
    @(negedge clk); rstN = 1;

    // preload by word store, little-endian
    access(1'b0, 1'b1, 2'd2, 1'b0, 32'h100, 16'h0, 32'hF0817263);
    check("R4 word store enables", {28'b0, sWe}, 32'hF);
    check("R5 word store data", sWdata, 32'hF0817263);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][37], 1'b0, VEC[i][36:35], VEC[i][34], 32'h100, {14'b0, VEC[i][33:32]}, 32'h0);
      check($sformatf("R6/R7 vector %0d", i), loadData, VEC[i][31:0]);
      check($sformatf("R8 loadDone vector %0d", i), {31'b0, loadDone}, 32'h1);
    end

    access(1'b1, 1'b0, 2'd2, 1'b0, 32'h100, 16'h0, 32'h0);
    check("R7 word load passthrough", loadData, 32'hF0817263);

    idle();
    check("R12 idle no enables", {28'b0, sWe}, 32'h0);
    check("R12 idle loadDone low", {31'b0, loadDone}, 32'h0);

    // R1: negative displacement and wrap
    access(1'b0, 1'b0, 2'd0, 1'b0, 32'h1000, 16'hFFFC, 32'h0);
    check("R1 negative offset", sAddr, 32'h00000FFC);
    access(1'b0, 1'b0, 2'd0, 1'b0, 32'hFFFFFFF0, 16'h0020, 32'h0);
    check("R1 wrap", sAddr, 32'h00000010);
    access(1'b0, 1'b0, 2'd0, 1'b0, 32'h10, 16'h7FFF, 32'h0);
    check("R1 max positive", sAddr, 32'h0000800F);

    // R2/R9: misaligned word store and load
    access(1'b0, 1'b0, 2'd2, 1'b0, 32'h100, 16'h0, 32'h0);
    access(1'b0, 1'b1, 2'd2, 1'b0, 32'h100, 16'h2, 32'hDEADBEEF);
    check("R2 word off2 fault", {31'b0, sFault}, 32'h1);
    check("R9 fault store no enables", {28'b0, sWe}, 32'h0);
    access(1'b0, 1'b0, 2'd2, 1'b0, 32'h100, 16'h1, 32'h0);
    check("R2 word off1 load fault", {31'b0, sFault}, 32'h1);
    check("R9 fault load holds data", loadData, 32'hF0817263);
    check("R9 fault load no done", {31'b0, loadDone}, 32'h0);
    access(1'b1, 1'b1, 2'd1, 1'b0, 32'h100, 16'h3, 32'h0);
    check("R2 half off3 fault", {31'b0, sFault}, 32'h1);
    access(1'b1, 1'b1, 2'd3, 1'b0, 32'h100, 16'h2, 32'h0);
    check("R2 reserved size as word fault", {31'b0, sFault}, 32'h1);
    access(1'b0, 1'b0, 2'd2, 1'b0, 32'h100, 16'h0, 32'h0);
    check("R9 memory untouched by faults", loadData, 32'hF0817263);

    // R3: byte at odd offsets
    access(1'b1, 1'b0, 2'd0, 1'b0, 32'h100, 16'h3, 32'h0);
    check("R3 byte off3 no fault", {31'b0, sFault}, 32'h0);

    // R4/R5 store enables and replication
    access(1'b1, 1'b1, 2'd0, 1'b0, 32'h10C, 16'h1, 32'h123456AB);
    check("R4 byte BE off1 enables", {28'b0, sWe}, 32'h4);
    check("R5 byte replication", sWdata, 32'hABABABAB);
    access(1'b0, 1'b1, 2'd1, 1'b0, 32'h10C, 16'h2, 32'h99991234);
    check("R4 half LE off2 enables", {28'b0, sWe}, 32'hC);
    check("R5 half replication", sWdata, 32'h12341234);
    access(1'b1, 1'b1, 2'd1, 1'b0, 32'h10C, 16'h2, 32'h5678);
    check("R4 half BE off2 enables", {28'b0, sWe}, 32'h3);
    access(1'b0, 1'b1, 2'd0, 1'b0, 32'h10C, 16'h1, 32'h77);
    check("R4 byte LE off1 enables", {28'b0, sWe}, 32'h2);

    // R11 ordering round trip
    for (int k = 0; k < 4; k++)
      access(1'b1, 1'b1, 2'd0, 1'b0, 32'h104, 16'(k), 32'h11 * (k + 1));
    access(1'b1, 1'b0, 2'd2, 1'b0, 32'h104, 16'h0, 32'h0);
    check("R11 big-endian word", loadData, 32'h11223344);
    for (int k = 0; k < 4; k++)
      access(1'b0, 1'b1, 2'd0, 1'b0, 32'h108, 16'(k), 32'h11 * (k + 1));
    access(1'b0, 1'b0, 2'd2, 1'b0, 32'h108, 16'h0, 32'h0);
    check("R11 little-endian word", loadData, 32'h44332211);

    idle();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule